// File: doc/BRIEF.md
# NAND Array Program/Erase Engine

This block is a behavioural NAND flash array built from synchronous RAM, paired with the engine that moves data between the array and an external page buffer. The array has a main area of sectors and a spare area with a smaller number of bytes per sector. Sectors are grouped four to a page and 64 pages to a block. A caller gives a block/page address pair, a sector count and an operation code, then pulses `start`. The engine turns the pair into a sector index and checks that index against the array size. It then streams one byte per clock between the array and the buffer port.

Programming follows NAND rules. A program can only clear bits, because each stored byte becomes the AND of its old value and the buffer byte. Erasing a block returns every main and spare byte of its 256 sectors to 0xFF. Copy-back first loads the source sectors into the buffer and then programs them into the destination. If an operation names a range that runs past the end of the array, it completes at once with an error code and leaves both the array and the buffer untouched.

Array sizes are parameters and are kept small, so that the block can be simulated.

Top module: `nand_array_engine`

## Requirements
- R1: The sector index of a block/page pair is {B, page[7:0]}. B is block[11:0], ORed with the DENSITY_MASK parameter when the upper-density flag block[12] is set. A block starts at sector B*256. Erase ignores the page.
- R2: Load-main (op 0) writes count*SECTOR_BYTES bytes to buffer offsets 0 upward. They come from main-area bytes starting at sector*SECTOR_BYTES. A count code of 0 means 4 sectors, and codes 1–3 mean themselves.
- R3: Program-main (op 2) replaces each target main byte with (stored AND buffer byte). Programming 0x5A and then 0xF0 over erased bytes leaves 0x50.
- R4: Load-spare (op 1) and program-spare (op 3) use spare bytes at sector*SPARE_BYTES, with the same AND rule. They leave the main area unchanged.
- R5: Erase (op 5) sets all main and all spare bytes of the addressed 256-sector block to 0xFF.
- R6: Copy-back (op 4) loads count sectors of main data from the source pair into the buffer. It then ANDs them into the destination sectors.
- R7: An operation fails if start+count (256 for erase) exceeds the sector total. Copy-back checks both of its ranges. A failing operation reports err = 1 (load), 2 (program or copy-back) or 3 (erase), writes neither array nor buffer, and finishes on the cycle after start. A range that ends exactly at the last sector is legal and reports err = 0.
- R8: `busy` rises on the cycle after an accepted start and stays high through a one-cycle `done` pulse. `start` is ignored while `busy` is high. `err` holds its value until the next accepted start.
- R9: After reset, busy, done, buf_we and err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 3 | Operation code (0..5) |
| cnt | input | 2 | Sector count code, 0 means 4 |
| src_blk | input | 13 | Source/target block: [11:0] number, [12] upper-density flag |
| src_page | input | 8 | Source/target page and sector within the block |
| dst_blk | input | 13 | Copy-back destination block |
| dst_page | input | 8 | Copy-back destination page |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Completion code: 0 ok, 1 load, 2 program, 3 erase |
| buf_addr | output | BUF_AW (5) | Buffer RAM byte address |
| buf_we | output | 1 | Buffer RAM write enable |
| buf_wdata | output | 8 | Buffer RAM write data |
| buf_rdata | input | 8 | Buffer RAM read data, one cycle after buf_addr |

## Verification
The bench targets the pair of programs that should leave 0x50. A design that overwrote stored bytes would leave 0xF0, and one that ORed them would leave 0xFA. Spare accesses are checked at non-zero sector offsets. Main data is loaded after a spare program, which catches a design that scaled the spare address by the main sector size or let a spare write reach the main area. Range errors are driven both one sector past the end and exactly at the end, and copy-back is driven with only a bad destination. A design with an off-by-one compare, or one that checked only the source, would either corrupt the last block or wrongly reject a legal access. A start pulse during a long erase tests that the request is dropped. A design that queued it would stay busy after the expected done pulse.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;

    localparam int SECT_PER_PAGE = 4;
    localparam int PAGES_PER_BLK = 64;
    localparam int SECT_PER_BLK  = SECT_PER_PAGE * PAGES_PER_BLK;
    localparam int MAX_CNT       = 4;

    typedef enum logic [2:0] {
        OP_LOAD_MAIN  = 3'd0,
        OP_LOAD_SPARE = 3'd1,
        OP_PROG_MAIN  = 3'd2,
        OP_PROG_SPARE = 3'd3,
        OP_COPY       = 3'd4,
        OP_ERASE      = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_LOAD  = 2'd1,
        ERR_PROG  = 2'd2,
        ERR_ERASE = 2'd3
    } err_e;

    typedef enum logic [1:0] {
        PK_LOAD  = 2'd0,
        PK_PROG  = 2'd1,
        PK_ERASE = 2'd2
    } pass_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_e;

endpackage

// File: rtl/nand_sector_map.sv
module nand_sector_map
    import nand_eng_pkg::*;
#(
    parameter int          NUM_SECTORS  = 512,
    parameter int          SI_W         = 9,
    parameter logic [11:0] DENSITY_MASK = 12'h001
) (
    input  logic [12:0]     blk,
    input  logic [7:0]      page,
    input  logic            whole_blk,
    input  logic [2:0]      n_sect,
    output logic [SI_W-1:0] sec,
    output logic            fits
);
    logic [11:0] blk_eff;
    logic [19:0] full_sec;
    logic [20:0] span;

    always_comb begin
        blk_eff  = blk[11:0] | (blk[12] ? DENSITY_MASK : 12'h000);
        // page[7:2] selects the page, page[1:0] the sector in it
        full_sec = whole_blk ? {blk_eff, 8'h00} : {blk_eff, page};
        span     = whole_blk ? 21'(SECT_PER_BLK) : 21'(n_sect);
        fits     = ({1'b0, full_sec} + span) <= 21'(NUM_SECTORS);
        sec      = full_sec[SI_W-1:0];
    end
endmodule

// File: rtl/nand_byte_ram.sv
module nand_byte_ram #(
    parameter int DEPTH = 4096,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/nand_xfer_ctrl.sv
module nand_xfer_ctrl
    import nand_eng_pkg::*;
#(
    parameter int SECTOR_BYTES = 8,
    parameter int SPARE_BYTES  = 4,
    parameter int SI_W         = 9,
    parameter int AW           = 12,
    parameter int LEN_W        = 12,
    parameter int BUF_AW       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op_i,
    input  logic [2:0]        cnt_n,
    input  logic [SI_W-1:0]   src_sec,
    input  logic              src_fit,
    input  logic [SI_W-1:0]   dst_sec,
    input  logic              dst_fit,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err,
    output logic [BUF_AW-1:0] buf_addr,
    output logic              buf_we,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata,
    output logic              main_re,
    output logic              spare_re,
    output logic [AW-1:0]     rd_addr,
    output logic              main_we,
    output logic              spare_we,
    output logic [AW-1:0]     wr_addr,
    output logic [7:0]        wr_data,
    input  logic [7:0]        main_rdata,
    input  logic [7:0]        spare_rdata
);
    typedef struct packed {
        state_e            st;
        op_e               op;
        logic [2:0]        cnt;
        logic [SI_W-1:0]   src;
        logic [SI_W-1:0]   dst;
        logic              pass;
        logic [LEN_W-1:0]  idx;
        logic              p_vld;
        logic [BUF_AW-1:0] p_idx;
        logic [AW-1:0]     p_addr;
        pass_kind_e        p_kind;
        logic              p_spare;
        err_e              err;
    } ctl_t;

    ctl_t r_q, r_d;

    // current pass descriptor
    pass_kind_e       cur_kind;
    logic             cur_spare;
    logic [SI_W-1:0]  cur_sec;
    logic [LEN_W-1:0] cur_len;
    logic             has_next;
    logic [AW-1:0]    cur_base;
    logic             issue;
    logic [7:0]       rd_byte;
    logic             ld_wr;
    logic             arr_wr;
    err_e             start_err;
    logic             op_known;

    always_comb begin
        cur_kind  = PK_LOAD;
        cur_spare = 1'b0;
        cur_sec   = r_q.src;
        cur_len   = LEN_W'(r_q.cnt) * LEN_W'(SECTOR_BYTES);
        has_next  = 1'b0;
        case (r_q.op)
            OP_LOAD_MAIN: ;
            OP_LOAD_SPARE: begin
                cur_spare = 1'b1;
                cur_len   = LEN_W'(r_q.cnt) * LEN_W'(SPARE_BYTES);
            end
            OP_PROG_MAIN: cur_kind = PK_PROG;
            OP_PROG_SPARE: begin
                cur_kind  = PK_PROG;
                cur_spare = 1'b1;
                cur_len   = LEN_W'(r_q.cnt) * LEN_W'(SPARE_BYTES);
            end
            OP_COPY: begin
                has_next = !r_q.pass;
                if (r_q.pass) begin
                    cur_kind = PK_PROG;
                    cur_sec  = r_q.dst;
                end
            end
            OP_ERASE: begin
                cur_kind  = PK_ERASE;
                has_next  = !r_q.pass;
                cur_spare = r_q.pass;
                cur_len   = r_q.pass ? LEN_W'(SECT_PER_BLK * SPARE_BYTES)
                                     : LEN_W'(SECT_PER_BLK * SECTOR_BYTES);
            end
            default: cur_len = '0;
        endcase
        cur_base = cur_spare ? AW'(cur_sec) * AW'(SPARE_BYTES)
                             : AW'(cur_sec) * AW'(SECTOR_BYTES);
        issue    = (r_q.st == ST_RUN) && (r_q.idx < cur_len);
    end

    // range check on the incoming request
    always_comb begin
        start_err = ERR_NONE;
        op_known  = 1'b1;
        case (op_e'(op_i))
            OP_LOAD_MAIN, OP_LOAD_SPARE: if (!src_fit) start_err = ERR_LOAD;
            OP_PROG_MAIN, OP_PROG_SPARE: if (!src_fit) start_err = ERR_PROG;
            OP_COPY:  if (!(src_fit && dst_fit)) start_err = ERR_PROG;
            OP_ERASE: if (!src_fit) start_err = ERR_ERASE;
            default:  op_known = 1'b0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                r_d.p_vld = 1'b0;
                if (start) begin
                    r_d.op   = op_e'(op_i);
                    r_d.cnt  = cnt_n;
                    r_d.src  = src_sec;
                    r_d.dst  = dst_sec;
                    r_d.pass = 1'b0;
                    r_d.idx  = '0;
                    r_d.err  = start_err;
                    r_d.st   = (start_err != ERR_NONE || !op_known) ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                r_d.p_vld = issue;
                if (issue) begin
                    r_d.idx     = r_q.idx + LEN_W'(1);
                    r_d.p_idx   = r_q.idx[BUF_AW-1:0];
                    r_d.p_addr  = cur_base + AW'(r_q.idx);
                    r_d.p_kind  = cur_kind;
                    r_d.p_spare = cur_spare;
                end else if (!r_q.p_vld) begin
                    if (has_next) begin
                        r_d.pass = 1'b1;
                        r_d.idx  = '0;
                    end else begin
                        r_d.st = ST_DONE;
                    end
                end
            end
            default: begin
                r_d.st    = ST_IDLE;
                r_d.p_vld = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        busy      = (r_q.st != ST_IDLE);
        done      = (r_q.st == ST_DONE);
        err       = r_q.err;
        main_re   = issue && (cur_kind != PK_ERASE) && !cur_spare;
        spare_re  = issue && (cur_kind != PK_ERASE) && cur_spare;
        rd_addr   = cur_base + AW'(r_q.idx);
        rd_byte   = r_q.p_spare ? spare_rdata : main_rdata;
        ld_wr     = r_q.p_vld && (r_q.p_kind == PK_LOAD);
        arr_wr    = r_q.p_vld && (r_q.p_kind != PK_LOAD);
        buf_we    = ld_wr;
        buf_addr  = ld_wr ? r_q.p_idx : r_q.idx[BUF_AW-1:0];
        buf_wdata = rd_byte;
        wr_data   = (r_q.p_kind == PK_ERASE) ? 8'hFF : (rd_byte & buf_rdata);
        main_we   = arr_wr && !r_q.p_spare;
        spare_we  = arr_wr && r_q.p_spare;
        wr_addr   = r_q.p_addr;
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(r_q.op) && $stable(r_q.src));
    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.err != ERR_NONE) |-> !(main_we || spare_we || buf_we));
    assert_load_no_array_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !(main_we || spare_we));
    assert_prog_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (main_we && r_q.p_kind == PK_PROG) |-> $past(main_re));
    assert_spare_prog_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spare_we && r_q.p_kind == PK_PROG) |-> $past(spare_re));
endmodule

// File: rtl/nand_array_engine.sv
module nand_array_engine
    import nand_eng_pkg::*;
#(
    parameter int          NUM_BLOCKS   = 2,
    parameter int          SECTOR_BYTES = 8,
    parameter int          SPARE_BYTES  = 4,
    parameter logic [11:0] DENSITY_MASK = 12'h001,
    localparam int         BUF_AW       = $clog2(MAX_CNT * SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [1:0]        cnt,
    input  logic [12:0]       src_blk,
    input  logic [7:0]        src_page,
    input  logic [12:0]       dst_blk,
    input  logic [7:0]        dst_page,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err,
    output logic [BUF_AW-1:0] buf_addr,
    output logic              buf_we,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata
);
    localparam int NUM_SECTORS = NUM_BLOCKS * SECT_PER_BLK;
    localparam int SI_W        = $clog2(NUM_SECTORS);
    localparam int MAIN_DEPTH  = NUM_SECTORS * SECTOR_BYTES;
    localparam int SPARE_DEPTH = NUM_SECTORS * SPARE_BYTES;
    localparam int MA_W        = $clog2(MAIN_DEPTH);
    localparam int SA_W        = $clog2(SPARE_DEPTH);
    localparam int LEN_W       = $clog2(SECT_PER_BLK * SECTOR_BYTES + 1);

    logic [2:0]      cnt_n;
    logic            src_whole;
    logic [SI_W-1:0] src_sec, dst_sec;
    logic            src_fit, dst_fit;
    logic            main_re, spare_re, main_we, spare_we;
    logic [MA_W-1:0] rd_addr, wr_addr;
    logic [7:0]      wr_data, main_rdata, spare_rdata;

    assign cnt_n     = (cnt == 2'd0) ? 3'd4 : {1'b0, cnt};
    assign src_whole = (op == OP_ERASE);

    nand_sector_map #(.NUM_SECTORS(NUM_SECTORS), .SI_W(SI_W), .DENSITY_MASK(DENSITY_MASK))
        u_src_map (.blk(src_blk), .page(src_page), .whole_blk(src_whole),
                   .n_sect(cnt_n), .sec(src_sec), .fits(src_fit));

    nand_sector_map #(.NUM_SECTORS(NUM_SECTORS), .SI_W(SI_W), .DENSITY_MASK(DENSITY_MASK))
        u_dst_map (.blk(dst_blk), .page(dst_page), .whole_blk(1'b0),
                   .n_sect(cnt_n), .sec(dst_sec), .fits(dst_fit));

    nand_xfer_ctrl #(
        .SECTOR_BYTES(SECTOR_BYTES), .SPARE_BYTES(SPARE_BYTES), .SI_W(SI_W),
        .AW(MA_W), .LEN_W(LEN_W), .BUF_AW(BUF_AW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op_i(op), .cnt_n(cnt_n),
        .src_sec(src_sec), .src_fit(src_fit), .dst_sec(dst_sec), .dst_fit(dst_fit),
        .busy(busy), .done(done), .err(err),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .main_re(main_re), .spare_re(spare_re), .rd_addr(rd_addr),
        .main_we(main_we), .spare_we(spare_we), .wr_addr(wr_addr), .wr_data(wr_data),
        .main_rdata(main_rdata), .spare_rdata(spare_rdata)
    );

    nand_byte_ram #(.DEPTH(MAIN_DEPTH), .AW(MA_W)) u_main_ram (
        .clk(clk), .re(main_re), .raddr(rd_addr), .rdata(main_rdata),
        .we(main_we), .waddr(wr_addr), .wdata(wr_data)
    );

    nand_byte_ram #(.DEPTH(SPARE_DEPTH), .AW(SA_W)) u_spare_ram (
        .clk(clk), .re(spare_re), .raddr(rd_addr[SA_W-1:0]), .rdata(spare_rdata),
        .we(spare_we), .waddr(wr_addr[SA_W-1:0]), .wdata(wr_data)
    );
endmodule

// File: tb/tb_nand_array_engine.sv
`timescale 1ns/1ps
module tb_nand_array_engine;
    localparam int SB = 8;
    localparam int SP = 4;
    localparam int NS = 512;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic [2:0]  op = 0;
    logic [1:0]  cnt = 0;
    logic [12:0] src_blk = 0, dst_blk = 0;
    logic [7:0]  src_page = 0, dst_page = 0;
    logic        busy, done, buf_we;
    logic [1:0]  err;
    logic [4:0]  buf_addr;
    logic [7:0]  buf_wdata;
    logic [7:0]  buf_rdata = 0;

    nand_array_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cnt(cnt),
        .src_blk(src_blk), .src_page(src_page), .dst_blk(dst_blk), .dst_page(dst_page),
        .busy(busy), .done(done), .err(err),
        .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    always #10 clk = ~clk;

    logic [7:0] bufm [32];
    logic [7:0] mm [NS*SB];
    logic [7:0] sm [NS*SP];
    logic [7:0] expb [32];
    int    exp_len = 0;
    int    wr_seen = 0;
    bit    op_active = 0;
    int    vecs = 0, bad = 0;
    int    cycles = 0;
    string cur_req = "R9";

    // buffer RAM owned by the bench
    always @(posedge clk) begin
        if (buf_we) bufm[buf_addr] <= buf_wdata;
        buf_rdata <= bufm[buf_addr];
    end

    // per-clock comparison against the reference model
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            $display("FAIL watchdog: run exceeded cycle limit (actual %0d expected <150000)", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
        if (rst_n) begin
            vecs++;
            if (busy !== op_active) begin
                bad++;
                $display("FAIL R8 busy: actual %b expected %b", busy, op_active);
            end
            if (buf_we) begin
                vecs++;
                wr_seen++;
                if (int'(buf_addr) >= exp_len || buf_wdata !== expb[buf_addr]) begin
                    bad++;
                    $display("FAIL %s buffer write @%0d: actual %h expected %h (len %0d)",
                             cur_req, buf_addr, buf_wdata, expb[buf_addr], exp_len);
                end
            end
        end
    end

    function automatic int sect(input logic [12:0] b, input logic [7:0] p);
        int be = int'(b[11:0]) | (b[12] ? 1 : 0);
        return be * 256 + int'(p);
    endfunction

    task automatic fill_buf(input int mode);
        @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            case (mode)
                0: bufm[i] = 8'h5A;
                1: bufm[i] = 8'hF0;
                2: bufm[i] = 8'(i * 7 + 3);
                default: bufm[i] = 8'(i) ^ 8'hC3;
            endcase
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic [1:0] c,
                          input logic [12:0] sb, input logic [7:0] sp,
                          input logic [12:0] db, input logic [7:0] dp,
                          input logic [1:0] exp_err, input string req, input bit poke);
        int n = (c == 0) ? 4 : int'(c);
        int ss = sect(sb, sp);
        int ds = sect(db, dp);
        int bs = (int'(sb[11:0]) | (sb[12] ? 1 : 0)) * 256;
        logic [7:0] snap [32];
        int waited = 0;
        cur_req = req;
        for (int i = 0; i < 32; i++) snap[i] = bufm[i];
        exp_len = 0;
        if (exp_err == 0) begin
            if (o == 3'd0 || o == 3'd4) begin
                exp_len = n * SB;
                for (int i = 0; i < n * SB; i++) expb[i] = mm[ss * SB + i];
            end else if (o == 3'd1) begin
                exp_len = n * SP;
                for (int i = 0; i < n * SP; i++) expb[i] = sm[ss * SP + i];
            end
        end
        wr_seen = 0;
        @(negedge clk);
        op = o; cnt = c; src_blk = sb; src_page = sp; dst_blk = db; dst_page = dp;
        start = 1;
        @(posedge clk);
        #1 op_active = 1;
        @(negedge clk);
        start = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 10) begin
                start = 1; op = 3'd0; src_blk = 13'd0; src_page = 8'd0;
            end
            if (poke && waited == 11) start = 0;
        end
        vecs++;
        if (!done) begin
            bad++;
            $display("FAIL %s done never seen: actual 0 expected 1", req);
        end
        vecs++;
        if (err !== exp_err) begin
            bad++;
            $display("FAIL %s err: actual %0d expected %0d", req, err, exp_err);
        end
        vecs++;
        if (wr_seen != exp_len) begin
            bad++;
            $display("FAIL %s buffer write count: actual %0d expected %0d", req, wr_seen, exp_len);
        end
        if (exp_err == 0) begin
            case (o)
                3'd2: for (int i = 0; i < n * SB; i++) mm[ss * SB + i] &= snap[i];
                3'd3: for (int i = 0; i < n * SP; i++) sm[ss * SP + i] &= snap[i];
                3'd4: for (int i = 0; i < n * SB; i++) mm[ds * SB + i] &= mm[ss * SB + i];
                3'd5: begin
                    for (int i = 0; i < 256 * SB; i++) mm[bs * SB + i] = 8'hFF;
                    for (int i = 0; i < 256 * SP; i++) sm[bs * SP + i] = 8'hFF;
                end
                default: ;
            endcase
        end
        @(posedge clk);
        #1 op_active = 0;
        exp_len = 0;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) bufm[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R9: reset state
        vecs++;
        if (busy !== 1'b0 || done !== 1'b0 || buf_we !== 1'b0 || err !== 2'd0) begin
            bad++;
            $display("FAIL R9 reset outputs: actual %b%b%b%0d expected 0000", busy, done, buf_we, err);
        end
        rst_n = 1;
        @(negedge clk);

        // R5 / R1: erase both blocks, block 1 via upper-density flag, page ignored
        run_op(3'd5, 2'd1, 13'h0000, 8'h00, 13'h0, 8'h0, 2'd0, "R5", 0);
        run_op(3'd5, 2'd1, 13'h1000, 8'h37, 13'h0, 8'h0, 2'd0, "R1", 0);
        // R2: count code 0 loads four sectors
        run_op(3'd0, 2'd0, 13'h0000, 8'h00, 13'h0, 8'h0, 2'd0, "R2", 0);
        // R3: AND programming, 0x5A then 0xF0 leaves 0x50
        fill_buf(0);
        run_op(3'd2, 2'd2, 13'h0001, 8'h05, 13'h0, 8'h0, 2'd0, "R3", 0);
        fill_buf(1);
        run_op(3'd2, 2'd2, 13'h0001, 8'h05, 13'h0, 8'h0, 2'd0, "R3", 0);
        run_op(3'd0, 2'd2, 13'h1000, 8'h05, 13'h0, 8'h0, 2'd0, "R3", 0);
        vecs++;
        if (mm[(256 + 5) * SB] !== 8'h50) begin
            bad++;
            $display("FAIL R3 model byte: actual %h expected 50", mm[(256 + 5) * SB]);
        end
        // R4: spare program and load at offset sectors, main untouched
        fill_buf(2);
        run_op(3'd3, 2'd3, 13'h0000, 8'h09, 13'h0, 8'h0, 2'd0, "R4", 0);
        run_op(3'd1, 2'd0, 13'h0000, 8'h08, 13'h0, 8'h0, 2'd0, "R4", 0);
        run_op(3'd0, 2'd1, 13'h0000, 8'h09, 13'h0, 8'h0, 2'd0, "R4", 0);
        // R6: copy-back
        fill_buf(3);
        run_op(3'd2, 2'd0, 13'h0000, 8'h20, 13'h0, 8'h0, 2'd0, "R6", 0);
        fill_buf(0);
        run_op(3'd4, 2'd0, 13'h0000, 8'h20, 13'h0001, 8'h40, 2'd0, "R6", 0);
        run_op(3'd0, 2'd0, 13'h0001, 8'h40, 13'h0, 8'h0, 2'd0, "R6", 0);
        // R7: range errors and the legal boundary
        run_op(3'd0, 2'd1, 13'h0002, 8'h00, 13'h0, 8'h0, 2'd1, "R7", 0);
        fill_buf(0);
        run_op(3'd2, 2'd2, 13'h0001, 8'hFF, 13'h0, 8'h0, 2'd2, "R7", 0);
        run_op(3'd0, 2'd2, 13'h0001, 8'hFE, 13'h0, 8'h0, 2'd0, "R7", 0);
        run_op(3'd5, 2'd1, 13'h0003, 8'h00, 13'h0, 8'h0, 2'd3, "R7", 0);
        run_op(3'd4, 2'd1, 13'h0000, 8'h20, 13'h0002, 8'h00, 2'd2, "R7", 0);
        run_op(3'd0, 2'd0, 13'h0000, 8'h20, 13'h0, 8'h0, 2'd0, "R7", 0);
        run_op(3'd3, 2'd0, 13'h0001, 8'hFC, 13'h0, 8'h0, 2'd0, "R7", 0);
        run_op(3'd1, 2'd0, 13'h0001, 8'hFC, 13'h0, 8'h0, 2'd0, "R7", 0);
        // R8: start during busy is dropped
        run_op(3'd5, 2'd1, 13'h0000, 8'h00, 13'h0, 8'h0, 2'd0, "R8", 1);
        repeat (4) @(negedge clk);
        run_op(3'd0, 2'd0, 13'h0000, 8'h20, 13'h0, 8'h0, 2'd0, "R8", 0);
        // R5: spare area cleared by erase
        run_op(3'd5, 2'd1, 13'h1000, 8'h00, 13'h0, 8'h0, 2'd0, "R5", 0);
        run_op(3'd1, 2'd0, 13'h0001, 8'hFC, 13'h0, 8'h0, 2'd0, "R5", 0);
        run_op(3'd0, 2'd0, 13'h0001, 8'h40, 13'h0, 8'h0, 2'd0, "R5", 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule